// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a bus-attached accelerator that turns an 8x8 tile of signed samples into its 64 two-dimensional forward cosine-transform coefficients. All the arithmetic is integer fixed point. Cosine weights and normalisation factors are 8-bit signed constants with six fraction bits, and every product is scaled back by an arithmetic shift of six.

A host drives it through four word registers on a simple strobe bus. It writes 64 samples to the sample-write register and writes the value 1 to the command register. It then reads the status register until the finished bit shows, and reads the 64 coefficients back from the coefficient-read register. Inside there is a sample store, a coefficient store, a cosine lookup and one multiplier. The multiplier is shared by every step of a sequential accumulate loop that produces one coefficient at a time.

Top module: `fdct_cop`

## Requirements
- R1: After reset the status register reads 0. The first sample written lands at index 0, and the first coefficient read comes from index 0.
- R2: The registers decode at status 16'hFFF7, command 16'hFFF8, sample write 16'hFFF9 and coefficient read 16'hFFFA. Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 otherwise. Reads of any other address return 0.
- R3: Each sample write stores into index r*8+c (row r, column c) and then advances the index. The index wraps after 64 writes, so a 65th write replaces index 0.
- R4: A write of exactly 1 to the command register while idle starts a transform. From the next cycle the status reads 2 (bit1 busy, bit0 finished clear). A command write of any other value has no effect.
- R5: Coefficient (u,v) equals ((((A*S(u))>>>6)*S(v))>>>6)>>>2, truncated to 16 bits. Here A is the sum over x,y of (((D(x,y)*K(x,u))>>>6)*K(y,v))>>>6.
- R6: K(p,f) = round(64*cos((2p+1)fπ/16)). S(0) = 45 and S(h) = 64 for h>0.
- R7: The transform stays busy for 8320 cycles (130 per coefficient). The status then reads 1, with bit0 finished set and busy clear, until the next start. Finished is never set while busy.
- R8: Coefficient reads return index u*8+v in order and wrap after 64. A start returns both the read index and the write index to 0.
- R9: While busy, sample writes and command writes are ignored. Coefficient reads return 0 and do not advance the read index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (16) | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W (16) | Read data, valid in the cycle after `bus_rd` |

## Verification
A corrupted loop counter, accumulator or operand selection shows up as a wrong coefficient. It appears in the first read of the block, or at the latest within 64 reads. A stuck or skipped sequencer state shows as a finished bit that appears too early or never, which is seen during status polling within a few cycles of the expected 8320. A store index that does not wrap, reset or hold makes every later coefficient land in the wrong order. That is exposed by deliberately wrapped writes, by an extra read past 64, and by accesses made while busy.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int BLK      = 8;
  localparam int NPIX     = BLK * BLK;
  localparam int IDX_W    = $clog2(NPIX);
  localparam int COS_W    = 8;
  localparam int FRAC_W   = 6;
  localparam int QUART_SH = 2;
  localparam logic signed [COS_W-1:0] SCALE_DC = 8'sd45;
  localparam logic signed [COS_W-1:0] SCALE_AC = 8'sd64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MUL1, ST_MUL2, ST_SCL1, ST_SCL2
  } eng_st_e;

  // quarter-wave cosine magnitudes, 6 fraction bits
  function automatic logic signed [COS_W-1:0] cos_mag(input logic [4:0] m);
    case (m)
      5'd0:    cos_mag = 8'sd64;
      5'd1:    cos_mag = 8'sd63;
      5'd2:    cos_mag = 8'sd59;
      5'd3:    cos_mag = 8'sd53;
      5'd4:    cos_mag = 8'sd45;
      5'd5:    cos_mag = 8'sd36;
      5'd6:    cos_mag = 8'sd24;
      5'd7:    cos_mag = 8'sd12;
      default: cos_mag = 8'sd0;
    endcase
  endfunction
endpackage

// File: rtl/fdct_cos_rom.sv
module fdct_cos_rom
  import fdct_pkg::*;
(
  input  logic [2:0]              pos,
  input  logic [2:0]              frq,
  output logic signed [COS_W-1:0] weight
);
  logic [6:0] phase;
  logic [4:0] k;

  always_comb begin
    phase = ({3'd0, pos, 1'b1}) * {4'd0, frq};
    k     = phase[4:0];
    if (k <= 5'd8)       weight = cos_mag(k);
    else if (k <= 5'd16) weight = -cos_mag(5'd16 - k);
    else if (k <= 5'd24) weight = -cos_mag(k - 5'd16);
    else                 weight = cos_mag(5'd0 - k);
  end

  logic unused_phase;
  assign unused_phase = ^phase[6:5];
endmodule

// File: rtl/fdct_engine.sv
module fdct_engine
  import fdct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] pix,
  output logic [IDX_W-1:0]  pix_idx,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data,
  output logic              busy,
  output logic              fin
);
  localparam int PROD_W = ACC_W + COS_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  eng_st_e st, nxt_st;
  logic [IDX_W-1:0] xy, nxt_xy, uv, nxt_uv;
  logic signed [ACC_W-1:0] acc, nxt_acc, tmp, nxt_tmp;

  logic [2:0] rom_pos, rom_frq;
  logic signed [COS_W-1:0] rom_w, mul_b;
  logic signed [ACC_W-1:0] mul_a, prod_lo;
  logic signed [PROD_W-1:0] ext_a, ext_b, prod;

  fdct_cos_rom i_rom (.pos(rom_pos), .frq(rom_frq), .weight(rom_w));

  // single shared multiplier with operand selection per state
  always_comb begin
    rom_pos = (st == ST_MUL1) ? xy[5:3] : xy[2:0];
    rom_frq = (st == ST_MUL1) ? uv[5:3] : uv[2:0];
    case (st)
      ST_MUL1: begin
        mul_a = {{(ACC_W-DATA_W){pix[DATA_W-1]}}, pix};
        mul_b = rom_w;
      end
      ST_SCL1: begin
        mul_a = acc;
        mul_b = (uv[5:3] == 3'd0) ? SCALE_DC : SCALE_AC;
      end
      ST_SCL2: begin
        mul_a = tmp;
        mul_b = (uv[2:0] == 3'd0) ? SCALE_DC : SCALE_AC;
      end
      default: begin
        mul_a = tmp;
        mul_b = rom_w;
      end
    endcase
    ext_a   = {{COS_W{mul_a[ACC_W-1]}}, mul_a};
    ext_b   = {{ACC_W{mul_b[COS_W-1]}}, mul_b};
    prod    = ext_a * ext_b;
    prod_lo = prod[FRAC_W +: ACC_W];
  end

  logic unused_prod;
  assign unused_prod = ^{prod[PROD_W-1:FRAC_W+ACC_W], prod[FRAC_W-1:0]};

  assign pix_idx  = xy;
  assign res_idx  = uv;
  assign res_data = prod_lo[QUART_SH +: DATA_W];
  assign busy     = (st != ST_IDLE);

  always_comb begin
    nxt_st  = st;
    nxt_xy  = xy;
    nxt_uv  = uv;
    nxt_acc = acc;
    nxt_tmp = tmp;
    res_we  = 1'b0;
    fin     = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt_st  = ST_MUL1;
        nxt_xy  = '0;
        nxt_uv  = '0;
        nxt_acc = '0;
      end
      ST_MUL1: begin
        nxt_tmp = prod_lo;
        nxt_st  = ST_MUL2;
      end
      ST_MUL2: begin
        nxt_acc = acc + prod_lo;
        if (xy == LAST) nxt_st = ST_SCL1;
        else begin
          nxt_xy = xy + 1'b1;
          nxt_st = ST_MUL1;
        end
      end
      ST_SCL1: begin
        nxt_tmp = prod_lo;
        nxt_st  = ST_SCL2;
      end
      ST_SCL2: begin
        res_we  = 1'b1;
        nxt_acc = '0;
        nxt_xy  = '0;
        if (uv == LAST) begin
          nxt_st = ST_IDLE;
          fin    = 1'b1;
        end else begin
          nxt_uv = uv + 1'b1;
          nxt_st = ST_MUL1;
        end
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      xy  <= '0;
      uv  <= '0;
      acc <= '0;
      tmp <= '0;
    end else begin
      st  <= nxt_st;
      xy  <= nxt_xy;
      uv  <= nxt_uv;
      acc <= nxt_acc;
      tmp <= nxt_tmp;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R4
  AST_BUSY_TILL_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy); // R7
endmodule

// File: rtl/fdct_bus_if.sv
module fdct_bus_if
  import fdct_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] A_STAT = 16'hFFF7,
  parameter logic [ADDR_W-1:0] A_CMD  = 16'hFFF8,
  parameter logic [ADDR_W-1:0] A_DIN  = 16'hFFF9,
  parameter logic [ADDR_W-1:0] A_DOUT = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              fin,
  output logic              start,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [DATA_W-1:0] pix,
  input  logic              res_we,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [DATA_W-1:0] res_data
);
  logic [DATA_W-1:0] ibuf [NPIX];
  logic [DATA_W-1:0] obuf [NPIX];
  logic [IDX_W-1:0]  widx, nxt_widx, ridx, nxt_ridx;
  logic              done, nxt_done;
  logic [DATA_W-1:0] nxt_rdata;
  logic              wr_din, rd_dout;

  assign wr_din  = bus_wr && (bus_addr == A_DIN) && !busy;
  assign rd_dout = bus_rd && (bus_addr == A_DOUT) && !busy;
  assign start   = bus_wr && (bus_addr == A_CMD) && !busy &&
                   (bus_wdata == DATA_W'(1));
  assign pix     = ibuf[pix_idx];

  always_comb begin
    nxt_widx  = widx;
    nxt_ridx  = ridx;
    nxt_done  = done;
    nxt_rdata = '0;
    if (start) begin
      nxt_widx = '0;
      nxt_ridx = '0;
      nxt_done = 1'b0;
    end else begin
      if (wr_din)  nxt_widx = widx + 1'b1;
      if (rd_dout) nxt_ridx = ridx + 1'b1;
      if (fin)     nxt_done = 1'b1;
    end
    if (bus_rd) begin
      if (bus_addr == A_STAT)      nxt_rdata = {{(DATA_W-2){1'b0}}, busy, done};
      else if (bus_addr == A_DOUT) nxt_rdata = busy ? '0 : obuf[ridx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx      <= '0;
      ridx      <= '0;
      done      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      widx      <= nxt_widx;
      ridx      <= nxt_ridx;
      done      <= nxt_done;
      bus_rdata <= nxt_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_din) ibuf[widx] <= bus_wdata;
    if (res_we) obuf[res_idx] <= res_data;
  end

  AST_BUSY_HOLDS_WIDX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIN && busy) |=> $stable(widx)); // R9
  AST_POP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DOUT && !busy) |=> (ridx == IDX_W'($past(ridx) + 1'b1))); // R8
  AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R7
  AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin)); // R7
endmodule

// File: rtl/fdct_cop.sv
module fdct_cop
  import fdct_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter logic [ADDR_W-1:0] A_STAT = 16'hFFF7,
  parameter logic [ADDR_W-1:0] A_CMD  = 16'hFFF8,
  parameter logic [ADDR_W-1:0] A_DIN  = 16'hFFF9,
  parameter logic [ADDR_W-1:0] A_DOUT = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic              busy, fin, start, res_we;
  logic [IDX_W-1:0]  pix_idx, res_idx;
  logic [DATA_W-1:0] pix, res_data;

  fdct_bus_if #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_STAT(A_STAT), .A_CMD(A_CMD), .A_DIN(A_DIN), .A_DOUT(A_DOUT)
  ) i_bus (
    .clk(clk), .rst_n(rst_sync),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .busy(busy), .fin(fin), .start(start),
    .pix_idx(pix_idx), .pix(pix),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data)
  );

  fdct_engine #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_eng (
    .clk(clk), .rst_n(rst_sync), .start(start), .pix(pix),
    .pix_idx(pix_idx), .res_we(res_we), .res_idx(res_idx),
    .res_data(res_data), .busy(busy), .fin(fin)
  );
endmodule

// File: tb/test_fdct_cop.sv
`timescale 1ns/1ps
module test_fdct_cop;
  localparam logic [15:0] A_STAT = 16'hFFF7;
  localparam logic [15:0] A_CMD  = 16'hFFF8;
  localparam logic [15:0] A_DIN  = 16'hFFF9;
  localparam logic [15:0] A_DOUT = 16'hFFFA;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [15:0] bus_rdata;

  always #4 clk = ~clk;

  fdct_cop i_fdct_cop (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_en = 1'b1;
  bit finished = 1'b0;
  int exp_q[$];
  int pix_a[64];
  int exp_a[64];
  int unsigned seed = 32'd12345;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor: every enabled coefficient read is compared in order
  always begin
    @(posedge clk);
    if (mon_en && bus_rd && bus_addr == A_DOUT) begin
      @(negedge clk);
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected read actual=%0d expected=none", bus_rdata);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (bus_rdata !== 16'(e)) begin
          bad++;
          $display("FAIL R5 R6 R8 coefficient actual=%0d expected=%0d",
                   $signed(bus_rdata), e);
        end
      end
    end
  end

  task automatic write_reg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic int rnd(input real r);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  function automatic int kcos(input int p, input int f);
    return rnd(64.0 * $cos(real'((2 * p + 1) * f) * PI / 16.0));
  endfunction

  function automatic int kscl(input int h);
    return (h == 0) ? rnd(64.0 / $sqrt(2.0)) : 64;
  endfunction

  task automatic model();
    for (int u = 0; u < 8; u++) begin
      for (int v = 0; v < 8; v++) begin
        longint a = 0;
        longint s;
        for (int x = 0; x < 8; x++) begin
          for (int y = 0; y < 8; y++) begin
            longint p1;
            p1 = (longint'(pix_a[x * 8 + y]) * kcos(x, u)) >>> 6;
            a += (p1 * kcos(y, v)) >>> 6;
          end
        end
        s = (a * kscl(u)) >>> 6;
        s = (s * kscl(v)) >>> 6;
        s = s >>> 2;
        exp_a[u * 8 + v] = int'($signed(16'(s)));
      end
    end
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < 64; i++) begin
      int r = i / 8;
      int c = i % 8;
      case (kind)
        0: pix_a[i] = 0;
        1: pix_a[i] = 100;
        2: pix_a[i] = i * 3 - 96;
        3: pix_a[i] = ((r + c) % 2 == 0) ? 100 : -100;
        4: begin
          seed = seed * 32'd1103515245 + 32'd12345;
          pix_a[i] = int'((seed >> 16) & 32'd255) - 128;
        end
        default: pix_a[i] = (r % 2 == 0) ? 127 : -128;
      endcase
    end
  endtask

  task automatic run_block(input int kind, input bit pre_junk,
                           input bit busy_poke, input bit extra_pop);
    logic [15:0] rd;
    int t0;
    fill(kind);
    model();
    if (pre_junk)  // R3: these 64 are overwritten after the index wraps
      for (int i = 0; i < 64; i++) write_reg(A_DIN, 16'(i * 7 + 1));
    for (int i = 0; i < 64; i++) write_reg(A_DIN, 16'(pix_a[i]));
    write_reg(A_CMD, 16'd1);
    t0 = cyc;
    read_reg(A_STAT, rd);
    check(rd == 16'd2, "R4 status busy after start", int'(rd), 2);
    if (busy_poke) begin
      for (int i = 0; i < 3; i++) write_reg(A_DIN, 16'h7FFF);
      write_reg(A_CMD, 16'd1);
      mon_en = 1'b0;
      read_reg(A_DOUT, rd);
      mon_en = 1'b1;
      check(rd == 16'd0, "R9 coefficient read while busy", int'(rd), 0);
      read_reg(A_STAT, rd);
      check(rd == 16'd2, "R9 status while busy", int'(rd), 2);
    end
    rd = '0;
    while (rd[0] == 1'b0) read_reg(A_STAT, rd);
    check((cyc - t0) >= 8321 && (cyc - t0) <= 8323, "R7 busy duration",
          cyc - t0, 8321);
    check(rd == 16'd1, "R7 status finished", int'(rd), 1);
    for (int i = 0; i < 64; i++) exp_q.push_back(exp_a[i]);
    if (extra_pop) exp_q.push_back(exp_a[0]);  // R8 wrap
    for (int i = 0; i < (extra_pop ? 65 : 64); i++) read_reg(A_DOUT, rd);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    logic [15:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(A_STAT, rd);
    check(rd == 16'd0, "R1 status after reset", int'(rd), 0);
    read_reg(16'h0000, rd);
    check(rd == 16'd0, "R2 unmapped address", int'(rd), 0);
    write_reg(A_CMD, 16'd3);
    read_reg(A_STAT, rd);
    check(rd == 16'd0, "R4 command value 3 ignored", int'(rd), 0);
    run_block(1, 1'b0, 1'b0, 1'b0);  // R1 first block from index 0
    write_reg(A_CMD, 16'd2);
    read_reg(A_STAT, rd);
    check(rd == 16'd1, "R4 command value 2 ignored", int'(rd), 1);
    run_block(0, 1'b0, 1'b0, 1'b0);
    run_block(2, 1'b1, 1'b0, 1'b1);  // R3 wrap, R8 wrap
    run_block(3, 1'b0, 1'b1, 1'b0);  // R8 start resets read index, R9
    run_block(4, 1'b0, 1'b0, 1'b0);
    run_block(5, 1'b0, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule